// File: doc/BRIEF.md
# Paged Indirect Register Access Master

This block turns one host request (page, offset, width code, write data, direction) into the series of word-level management register accesses needed to reach a paged register space. That space sits behind a single fixed management address. Downstream it drives a clause-22 style register port: a PHY address, a register number, 16-bit data, and write or read strobes. Each strobe is held until the port answers with a done pulse, which may carry an error flag.

A write first loads the data registers. It then selects the page, issues the command and polls the command register until the operation bits clear. A read selects the page, issues the command, polls, and then collects the data registers from the highest index down to the lowest. Each collected word is shifted into an accumulator. The host sees a one-cycle done pulse with an error flag and the read result. The block takes a new request only while it is idle.

Top module: `pgreg_master`

## Requirements
- R1: Every downstream access uses PHY address PHY_ADDR (default 30), and at most one of the write and read strobes is high at a time.
- R2: Width codes are 0=8, 1=16, 2=32, 3=48 and 4=64 bits. A write loads 1, 1, 2, 3 or 4 data registers, starting at register 0x18 and going upward. The least significant 16 bits go to 0x18, and an 8-bit write loads the byte zero-extended. These loads come before any other access of the operation.
- R3: The page-select access writes register 0x10 with the page in bits 15:8 and bit 0 set. It is the first access of a read and follows the data loads of a write.
- R4: The command access writes register 0x11 with the offset in bits 15:8. Bit 0 is set for a write and bit 1 for a read; bits 7:2 are zero.
- R5: After the command, register 0x11 is read until its bits 1:0 are both zero, and the upper bits of the value read are ignored. Exactly POLL_GAP cycles with no strobe lie between two consecutive polls.
- R6: If bits 1:0 are still non-zero on poll number POLL_LIMIT (default 5), the operation ends with the error flag set and no data register is read.
- R7: A successful read then reads the data registers from the highest index down to 0x18 and shifts the result left 16 bits per word. An 8-bit read returns only the low byte of 0x18, zero-extended.
- R8: A downstream done with the error flag ends the operation at once with the host error flag set, and no further access is made.
- R9: Width codes 5 to 7 make no downstream access; done and error are reported in the cycle after the request.
- R10: req_ready is high only while idle. A req_valid seen while busy starts nothing and produces no extra access or done.
- R11: rsp_done is a one-cycle pulse raised after the final downstream done. rsp_rdata is zero for writes and for failed operations, and rsp_error is low for successful ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 8 | Target page |
| req_offset | input | 8 | Register offset within the page |
| req_width | input | 3 | Width code (0..4 valid) |
| req_wdata | input | 64 | Write data, least significant bits used |
| req_ready | output | 1 | Block idle and able to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Completion carried an error |
| rsp_rdata | output | 64 | Read result |
| mg_phy | output | 5 | Downstream PHY address |
| mg_reg | output | 5 | Downstream register number |
| mg_wdata | output | 16 | Downstream write data |
| mg_wr | output | 1 | Downstream write strobe, held until mg_done |
| mg_rd | output | 1 | Downstream read strobe, held until mg_done |
| mg_done | input | 1 | Downstream access complete |
| mg_err | input | 1 | Downstream access failed, valid with mg_done |
| mg_rdata | input | 16 | Downstream read data, valid with mg_done |

## Verification
The bench builds the block with POLL_LIMIT=5 and POLL_GAP=3. The short gap keeps each polling run within a few dozen cycles. The bench can then drive the busy count right up to the limit (four busy polls pass, five fail) and still check the exact idle gap before every repeated poll. The five-poll limit, together with a downstream model that answers after three cycles, lets directed cases place an injected error on the first access, on a poll, or on a data load.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam int WORD_W    = 16;
  localparam int MAX_WORDS = 4;
  localparam int DATA_W    = WORD_W * MAX_WORDS;

  localparam logic [4:0] REG_PAGE  = 5'h10;
  localparam logic [4:0] REG_CMD   = 5'h11;
  localparam logic [4:0] REG_DATA0 = 5'h18;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [2:0] WID_8  = 3'd0;
  localparam logic [2:0] WID_16 = 3'd1;
  localparam logic [2:0] WID_32 = 3'd2;
  localparam logic [2:0] WID_48 = 3'd3;
  localparam logic [2:0] WID_64 = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WDATA,
    ST_PAGE,
    ST_CMD,
    ST_POLL,
    ST_WAIT,
    ST_RDATA
  } seq_state_e;
endpackage

// File: rtl/pgreg_width_dec.sv
module pgreg_width_dec
  import pgreg_pkg::*;
(
  input  logic [2:0]        code,
  output logic              valid,
  output logic [2:0]        nwords,
  output logic [DATA_W-1:0] mask
);
  always_comb begin
    valid  = 1'b1;
    nwords = 3'd1;
    case (code)
      WID_8:   nwords = 3'd1;
      WID_16:  nwords = 3'd1;
      WID_32:  nwords = 3'd2;
      WID_48:  nwords = 3'd3;
      WID_64:  nwords = 3'd4;
      default: begin
        valid  = 1'b0;
        nwords = 3'd1;
      end
    endcase
  end

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word_mask
    if (w == 0) begin : g_low
      assign mask[WORD_W-1:0] = (code == WID_8) ? {{(WORD_W/2){1'b0}}, {(WORD_W/2){1'b1}}}
                                                : {WORD_W{1'b1}};
    end else begin : g_high
      assign mask[w*WORD_W +: WORD_W] = (3'(w) < nwords) ? {WORD_W{1'b1}} : {WORD_W{1'b0}};
    end
  end
endmodule

// File: rtl/pgreg_poll_timer.sv
module pgreg_poll_timer #(
  parameter int GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CW'(GAP - 1);
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || run) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R5
  timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(GAP - 1));
endmodule

// File: rtl/pgreg_rd_accum.sv
module pgreg_rd_accum
  import pgreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic [WORD_W-1:0] word_in,
  output logic [DATA_W-1:0] acc_nxt
);
  logic [DATA_W-1:0] acc_q, acc_d;

  assign acc_nxt = {acc_q[DATA_W-WORD_W-1:0], word_in};

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (shift) begin
      acc_d = acc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr || shift) begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/pgreg_master.sv
module pgreg_master
  import pgreg_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR   = 5'd30,
  parameter int         POLL_LIMIT = 5,
  parameter int         POLL_GAP   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_page,
  input  logic [7:0]  req_offset,
  input  logic [2:0]  req_width,
  input  logic [63:0] req_wdata,
  output logic        req_ready,
  output logic        rsp_done,
  output logic        rsp_error,
  output logic [63:0] rsp_rdata,
  output logic [4:0]  mg_phy,
  output logic [4:0]  mg_reg,
  output logic [15:0] mg_wdata,
  output logic        mg_wr,
  output logic        mg_rd,
  input  logic        mg_done,
  input  logic        mg_err,
  input  logic [15:0] mg_rdata
);
  localparam int PCW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int IW  = $clog2(MAX_WORDS);

  seq_state_e        state_q, state_d;
  logic [7:0]        page_q, off_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q, mask_q;
  logic [2:0]        nwords_q;
  logic [IW-1:0]     widx_q, widx_d;
  logic [PCW-1:0]    poll_q, poll_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic              wid_ok;
  logic [2:0]        wid_nwords;
  logic [DATA_W-1:0] wid_mask;
  logic              accept, fin_en;
  logic              acc_clr, acc_shift;
  logic [DATA_W-1:0] acc_nxt;
  logic              tmr_load, tmr_expired;
  logic [IW-1:0]     last_idx;

  pgreg_width_dec u_wdec (
    .code   (req_width),
    .valid  (wid_ok),
    .nwords (wid_nwords),
    .mask   (wid_mask)
  );

  pgreg_poll_timer #(.GAP(POLL_GAP)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .run     (state_q == ST_WAIT),
    .expired (tmr_expired)
  );

  pgreg_rd_accum u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acc_clr),
    .shift   (acc_shift),
    .word_in (mg_rdata),
    .acc_nxt (acc_nxt)
  );

  assign last_idx  = IW'(nwords_q - 3'd1);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Downstream port decode from the sequencer state
  always_comb begin
    mg_phy   = PHY_ADDR;
    mg_wr    = 1'b0;
    mg_rd    = 1'b0;
    mg_reg   = REG_CMD;
    mg_wdata = '0;
    case (state_q)
      ST_WDATA: begin
        mg_wr    = 1'b1;
        mg_reg   = REG_DATA0 + 5'(widx_q);
        mg_wdata = wdata_q[{widx_q, 4'b0000} +: WORD_W];
      end
      ST_PAGE: begin
        mg_wr    = 1'b1;
        mg_reg   = REG_PAGE;
        mg_wdata = {page_q, 8'h01};
      end
      ST_CMD: begin
        mg_wr    = 1'b1;
        mg_reg   = REG_CMD;
        mg_wdata = {off_q, 6'b000000, (write_q ? OP_WRITE : OP_READ)};
      end
      ST_POLL: begin
        mg_rd  = 1'b1;
        mg_reg = REG_CMD;
      end
      ST_RDATA: begin
        mg_rd  = 1'b1;
        mg_reg = REG_DATA0 + 5'(widx_q);
      end
      default: ;
    endcase
  end

  // Sequencer next state
  always_comb begin
    state_d   = state_q;
    widx_d    = widx_q;
    poll_d    = poll_q;
    done_d    = 1'b0;
    err_d     = err_q;
    rdata_d   = rdata_q;
    fin_en    = 1'b0;
    acc_clr   = 1'b0;
    acc_shift = 1'b0;
    tmr_load  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!wid_ok) begin
            fin_en  = 1'b1;
            done_d  = 1'b1;
            err_d   = 1'b1;
            rdata_d = '0;
          end else begin
            acc_clr = 1'b1;
            widx_d  = '0;
            state_d = req_write ? ST_WDATA : ST_PAGE;
          end
        end
      end
      ST_WDATA, ST_PAGE, ST_CMD, ST_POLL, ST_RDATA: begin
        if (mg_done && mg_err) begin
          state_d = ST_IDLE;
          fin_en  = 1'b1;
          done_d  = 1'b1;
          err_d   = 1'b1;
          rdata_d = '0;
        end else if (mg_done) begin
          case (state_q)
            ST_WDATA: begin
              if (widx_q == last_idx) state_d = ST_PAGE;
              else widx_d = widx_q + 1'b1;
            end
            ST_PAGE: state_d = ST_CMD;
            ST_CMD: begin
              state_d = ST_POLL;
              poll_d  = '0;
            end
            ST_POLL: begin
              if (mg_rdata[1:0] == 2'b00) begin
                if (write_q) begin
                  state_d = ST_IDLE;
                  fin_en  = 1'b1;
                  done_d  = 1'b1;
                  err_d   = 1'b0;
                  rdata_d = '0;
                end else begin
                  state_d = ST_RDATA;
                  widx_d  = last_idx;
                end
              end else if (poll_q == PCW'(POLL_LIMIT - 1)) begin
                state_d = ST_IDLE;
                fin_en  = 1'b1;
                done_d  = 1'b1;
                err_d   = 1'b1;
                rdata_d = '0;
              end else begin
                poll_d   = poll_q + 1'b1;
                state_d  = ST_WAIT;
                tmr_load = 1'b1;
              end
            end
            ST_RDATA: begin
              acc_shift = 1'b1;
              if (widx_q == '0) begin
                state_d = ST_IDLE;
                fin_en  = 1'b1;
                done_d  = 1'b1;
                err_d   = 1'b0;
                rdata_d = acc_nxt & mask_q;
              end else begin
                widx_d = widx_q - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      ST_WAIT: begin
        if (tmr_expired) state_d = ST_POLL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      poll_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
      poll_q  <= poll_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      off_q    <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      mask_q   <= '0;
      nwords_q <= 3'd1;
    end else if (accept && wid_ok) begin
      page_q   <= req_page;
      off_q    <= req_offset;
      write_q  <= req_write;
      wdata_q  <= req_wdata & wid_mask;
      mask_q   <= wid_mask;
      nwords_q <= wid_nwords;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else if (fin_en) begin
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_error = err_q;
  assign rsp_rdata = rdata_q;

  // R1
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mg_wr && mg_rd));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mg_wr || mg_rd));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  // R5
  gap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL && $past(state_q) == ST_WAIT) |-> $past(tmr_expired));

  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= PCW'(POLL_LIMIT - 1));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_done && mg_err && (mg_wr || mg_rd)) |=> (req_ready && rsp_done && rsp_error));

  // R9
  bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !wid_ok) |=> (rsp_done && rsp_error && req_ready));
endmodule

// File: tb/pgreg_master_tb.sv
module pgreg_master_tb_top;
  localparam int LIMIT = 5;
  localparam int GAP   = 3;
  localparam int LAT   = 3;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_page, req_offset;
  logic [2:0]  req_width;
  logic [63:0] req_wdata;
  logic        req_ready, rsp_done, rsp_error;
  logic [63:0] rsp_rdata;
  logic [4:0]  mg_phy, mg_reg;
  logic [15:0] mg_wdata;
  logic        mg_wr, mg_rd;
  logic        mg_done, mg_err;
  logic [15:0] mg_rdata;

  pgreg_master #(.PHY_ADDR(5'd30), .POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_page(req_page),
    .req_offset(req_offset), .req_width(req_width), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata),
    .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_wdata(mg_wdata),
    .mg_wr(mg_wr), .mg_rd(mg_rd), .mg_done(mg_done), .mg_err(mg_err),
    .mg_rdata(mg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // ---------------- downstream register space model ----------------
  logic [63:0] mem [0:15];
  logic [15:0] dreg [0:3];
  logic [7:0]  m_page;
  logic [1:0]  m_op;
  int          busy_left, busy_cfg, err_at, cnt, idle_run, gap_hold, tr_n, phy_bad;
  logic        clr_req;
  logic        tr_wr  [0:31];
  logic [4:0]  tr_reg [0:31];
  logic [15:0] tr_dat [0:31];
  int          tr_gap [0:31];
  logic [15:0] rv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mg_done <= 1'b0; mg_err <= 1'b0; mg_rdata <= 16'h0;
      cnt <= 0; idle_run <= 0; gap_hold <= 0; tr_n <= 0; phy_bad <= 0;
      busy_left <= 0; m_op <= 2'b00; m_page <= 8'h00;
      for (int i = 0; i < 4; i++) dreg[i] <= 16'h0;
      for (int i = 0; i < 16; i++) mem[i] <= 64'h0;
    end else begin
      if (clr_req) tr_n <= 0;
      if ((mg_wr || mg_rd) && (mg_phy != 5'd30 || (mg_wr && mg_rd))) phy_bad <= phy_bad + 1;
      if (mg_done) begin
        mg_done <= 1'b0; mg_err <= 1'b0; cnt <= 0; idle_run <= 0;
      end else if (mg_wr || mg_rd) begin
        idle_run <= 0;
        cnt <= cnt + 1;
        if (cnt == 0) gap_hold <= idle_run;
        if (cnt == LAT - 1) begin
          mg_done <= 1'b1;
          tr_wr[tr_n] <= mg_wr; tr_reg[tr_n] <= mg_reg; tr_gap[tr_n] <= gap_hold;
          tr_n <= tr_n + 1;
          if (tr_n == err_at) begin
            mg_err <= 1'b1; mg_rdata <= 16'h0; tr_dat[tr_n] <= mg_wdata;
          end else if (mg_wr) begin
            tr_dat[tr_n] <= mg_wdata;
            if (mg_reg == 5'h10) m_page <= mg_wdata[15:8];
            else if (mg_reg == 5'h11) begin
              m_op <= mg_wdata[1:0];
              busy_left <= busy_cfg;
              if (mg_wdata[1:0] == 2'b01)
                mem[{m_page[1:0], mg_wdata[9:8]}] <= {dreg[3], dreg[2], dreg[1], dreg[0]};
              else if (mg_wdata[1:0] == 2'b10)
                for (int i = 0; i < 4; i++)
                  dreg[i] <= mem[{m_page[1:0], mg_wdata[9:8]}][i*16 +: 16];
            end else if (mg_reg >= 5'h18 && mg_reg <= 5'h1b) dreg[mg_reg - 5'h18] <= mg_wdata;
          end else begin
            if (mg_reg == 5'h11) begin
              if (busy_left > 0) begin rv = {8'hA5, 6'b0, m_op}; busy_left <= busy_left - 1; end
              else rv = 16'h5A00;
            end else if (mg_reg >= 5'h18 && mg_reg <= 5'h1b) rv = dreg[mg_reg - 5'h18];
            else rv = 16'hDEAD;
            mg_rdata <= rv; tr_dat[tr_n] <= rv;
          end
        end
      end else idle_run <= idle_run + 1;
    end
  end

  // ---------------- bench reference ----------------
  function automatic int words_of(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: return 1;
      3'd2: return 2;
      3'd3: return 3;
      3'd4: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] mask_of(input logic [2:0] c);
    case (c)
      3'd0: return 64'hFF;
      3'd1: return 64'hFFFF;
      3'd2: return 64'hFFFF_FFFF;
      3'd3: return 64'hFFFF_FFFF_FFFF;
      3'd4: return 64'hFFFF_FFFF_FFFF_FFFF;
      default: return 64'h0;
    endcase
  endfunction

  logic        ex_wr  [0:31];
  logic [4:0]  ex_reg [0:31];
  logic [15:0] ex_dat [0:31];
  int          ex_gap [0:31];
  int          ex_n;

  task automatic push(input logic w, input logic [4:0] r, input logic [15:0] d, input int g);
    ex_wr[ex_n] = w; ex_reg[ex_n] = r; ex_dat[ex_n] = d; ex_gap[ex_n] = g;
    ex_n++;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input logic [7:0] pg, input logic [7:0] of,
                        input logic [2:0] wc, input logic [63:0] wd, input int busy,
                        input int errat, input bit poke);
    int nw, np, dones, first_done, full, mism;
    logic got_err, exp_err;
    logic [63:0] got_rd, exp_rd, stored, m;
    nw = words_of(wc);
    m = mask_of(wc);
    stored = mem[{pg[1:0], of[1:0]}];
    ex_n = 0;
    if (nw > 0) begin
      if (wr) for (int i = 0; i < nw; i++) push(1'b1, 5'(5'h18 + i), 16'((wd & m) >> (16*i)), 0);
      push(1'b1, 5'h10, {pg, 8'h01}, 0);
      push(1'b1, 5'h11, {of, 6'b0, (wr ? 2'b01 : 2'b10)}, 0);
      np = (busy < LIMIT) ? busy + 1 : LIMIT;
      for (int k = 0; k < np; k++) push(1'b0, 5'h11, 16'h0, (k > 0) ? GAP : 0);
      if (!wr && busy < LIMIT) for (int i = nw - 1; i >= 0; i--) push(1'b0, 5'(5'h18 + i), 16'h0, 0);
    end
    full = ex_n;
    if (errat >= 0 && errat < full) ex_n = errat + 1;
    exp_err = (nw == 0) || (busy >= LIMIT) || (errat >= 0 && errat < full);
    exp_rd = (!exp_err && !wr) ? (stored & m) : 64'h0;

    busy_cfg = busy; err_at = errat;
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    req_valid = 1'b1; req_write = wr; req_page = pg; req_offset = of;
    req_width = wc; req_wdata = wd;
    @(negedge clk); req_valid = 1'b0;
    dones = 0; first_done = -1; got_err = 1'b0; got_rd = 64'h0;
    for (int t = 0; t < 400; t++) begin
      if (poke && t == 4) begin
        req_valid = 1'b1; req_write = 1'b1; req_width = 3'd1; req_page = 8'hFF;
      end else req_valid = 1'b0;
      if (rsp_done) begin
        dones++;
        if (first_done < 0) first_done = t;
        got_err = rsp_error; got_rd = rsp_rdata;
      end
      if (dones > 0 && t > first_done + 8) break;
      @(negedge clk);
    end
    req_valid = 1'b0;

    chk(dones == 1, "R11 single done pulse", 64'(dones), 64'd1);
    chk(got_err == exp_err, "R6 R8 R9 error flag", 64'(got_err), 64'(exp_err));
    chk(got_rd == exp_rd, "R7 R11 read result", got_rd, exp_rd);
    chk(phy_bad == 0, "R1 phy address and strobes", 64'(phy_bad), 64'd0);
    mism = 0;
    if (tr_n == ex_n)
      for (int i = 0; i < ex_n; i++) begin
        if (tr_wr[i] != ex_wr[i] || tr_reg[i] != ex_reg[i]) mism++;
        else if (ex_wr[i] && tr_dat[i] != ex_dat[i]) mism++;
        else if (i > 0 && tr_gap[i] != ex_gap[i]) mism++;
      end
    chk(tr_n == ex_n && mism == 0, "R2 R3 R4 R5 R7 R10 access sequence",
        64'(tr_n) << 8 | 64'(mism), 64'(ex_n) << 8);
    if (nw == 0) chk(first_done == 0, "R9 immediate completion", 64'(first_done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_page = 8'h0;
    req_offset = 8'h0; req_width = 3'd0; req_wdata = 64'h0; clr_req = 1'b0;
    busy_cfg = 0; err_at = -1;
    seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_done == 1'b0 && !mg_wr && !mg_rd, "R11 quiet after reset",
        64'({rsp_done, mg_wr, mg_rd}), 64'd0);

    // Directed corners
    run_op(1'b1, 8'h12, 8'h01, 3'd4, 64'h1122_3344_5566_7788, 0, -1, 1'b0); // R2 64-bit write
    run_op(1'b0, 8'h12, 8'h01, 3'd4, 64'h0, 2, -1, 1'b0);                   // R7 64-bit read
    run_op(1'b1, 8'h20, 8'h03, 3'd0, 64'hFFFF_FFFF_FFFF_ABCD, 1, -1, 1'b0); // R2 byte zero-extend
    run_op(1'b0, 8'h20, 8'h03, 3'd1, 64'h0, 0, -1, 1'b0);                   // R7 reads 0x00CD
    run_op(1'b0, 8'h12, 8'h01, 3'd0, 64'h0, 0, -1, 1'b0);                   // R7 low byte only
    run_op(1'b0, 8'h12, 8'h01, 3'd2, 64'h0, LIMIT - 1, -1, 1'b0);           // R5 last poll clears
    run_op(1'b0, 8'h12, 8'h01, 3'd3, 64'h0, LIMIT, -1, 1'b0);               // R6 exhaustion
    run_op(1'b1, 8'h05, 8'h02, 3'd2, 64'hCAFE_F00D, LIMIT + 2, -1, 1'b0);   // R6 on write
    run_op(1'b0, 8'h12, 8'h01, 3'd4, 64'h0, 0, 0, 1'b0);                    // R8 first access
    run_op(1'b1, 8'h12, 8'h02, 3'd3, 64'h0000_AAAA_BBBB_CCCC, 2, 6, 1'b0);  // R8 on a poll
    run_op(1'b1, 8'h12, 8'h02, 3'd4, 64'h0, 0, 2, 1'b0);                    // R8 on a data load
    run_op(1'b1, 8'h12, 8'h01, 3'd6, 64'h0, 0, -1, 1'b0);                   // R9 bad width
    run_op(1'b0, 8'h12, 8'h01, 3'd5, 64'h0, 0, -1, 1'b0);                   // R9 bad width read
    run_op(1'b1, 8'h33, 8'h00, 3'd2, 64'h0BAD_BEEF, 3, -1, 1'b1);           // R10 request while busy
    run_op(1'b0, 8'h33, 8'h00, 3'd2, 64'h0, 0, -1, 1'b1);                   // R10 read with poke

    // Constrained random: write then read back
    for (int n = 0; n < 30; n++) begin
      logic [7:0] pg, of;
      logic [2:0] wc, rc;
      logic [63:0] wd;
      pg = 8'($urandom); of = 8'($urandom);
      wc = 3'($urandom % 5); rc = ($urandom % 4 == 0) ? 3'($urandom % 5) : wc;
      wd = {$urandom, $urandom};
      run_op(1'b1, pg, of, wc, wd, int'($urandom % 4), ($urandom % 8 == 0) ? int'($urandom % 6) : -1, 1'b0);
      run_op(1'b0, pg, of, rc, 64'h0, int'($urandom % 6), -1, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule